// File: doc/BRIEF.md
# Stream-Tagged Translation Cache with Selective Flush

This block keeps a small, fully associative set of finished leaf translations in front of a page table walker. Each entry is tagged by a stream number and a 16 KiB virtual page number, which is the address shifted right by 14. A request that matches an entry gets its physical page number on the next cycle. A request that misses is passed to the walker. A successful walk result is returned to the requester and also written into the cache. If the walker reports an invalid leaf, the block asks it once more with a flag that forces a fresh memory read. Only a second failure is reported as a fault.

A small register port holds a stream enable mask, a stream selection mask and a command register. Writing the invalidate bit of the command register starts a sweep over every entry, one entry per clock. The sweep drops each entry whose stream is set in the selection mask. While the sweep runs, a busy bit reads high and lookups are held off. Requests from streams that are not enabled are refused with a fault and never reach the walker.

Top module: `stream_xlate_cache`

## Requirements
- R1: A request whose stream and page number (address bits above bit 13) match a valid entry is accepted and, in the next cycle, gives rsp_valid=1, rsp_fault=0 and the stored page number, with no walker request.
- R2: A missing request from an enabled stream raises walk_req for one cycle, starting the cycle after acceptance, with walk_fresh=0 and the request's stream and page number. A later walk_done with walk_ok=1 gives a response the next cycle carrying walk_ppn and installs the translation.
- R3: If the first walk ends with walk_ok=0, walk_req is raised again the next cycle with walk_fresh=1. If this second walk also fails, the response has rsp_fault=1 and nothing is cached. If it succeeds, its page number is returned and cached.
- R4: Register address 2 is the stream enable mask (bit s enables stream s, reset 0). A request from a disabled stream gets rsp_valid=1 and rsp_fault=1 in the next cycle and causes no walk.
- R5: Entries are told apart by stream as well as page. The same page from another stream misses, and an address that differs only in bits 13..0 hits.
- R6: A write to register address 1 with bit 20 set, while idle, makes bit 2 of address 1 read 1 from the next cycle on, for exactly ENTRIES cycles.
- R7: An invalidation removes exactly the entries whose stream bit is set in the selection mask. That mask lives at register address 0 and is captured when the command is written. Entries of other streams still hit afterwards.
- R8: req_ready is low while an invalidation is busy and while a lookup is waiting for the walker.
- R9: A walk that completes while an invalidation is busy still returns its result, but the result is not cached.
- R10: New translations are placed in round-robin order, so with every slot full the oldest installed entry is the one replaced.
- R11: After reset, req_ready=1, rsp_valid=0, walk_req=0, and all three registers read 0.
- R12: A command write with bit 20 clear starts no invalidation and leaves cached entries intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 selection, 1 command, 2 enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_stream | input | SID_W (4) | Requesting stream |
| req_iova | input | VA_W (32) | Virtual address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Response carries a fault |
| rsp_ppn | output | PPN_W (22) | Physical page number |
| walk_req | output | 1 | One-cycle walk start strobe |
| walk_fresh | output | 1 | Walk must bypass any table copy and reread memory |
| walk_stream | output | SID_W (4) | Stream of the walk |
| walk_vpn | output | VPN_W (18) | Page number to walk |
| walk_done | input | 1 | Walk finished |
| walk_ok | input | 1 | Walk found a valid leaf |
| walk_ppn | input | PPN_W (22) | Page number found by the walk |

## Verification
The assertions check on every cycle the causal rules of the handshake. No acceptance happens while a walker strobe is out. Every fresh-read walk follows a failed walk. Every plain walk follows an accepted request. Disabled streams are refused at once. The busy flag rises only after an invalidate command and falls only after the last slot. Lookup tags also stay unique. Which entries survive a selective flush, round-robin eviction order, and the dropped fill of a walk that finishes under a flush depend on earlier traffic. Only the bench's directed scenarios show these, by replaying requests and watching whether a walk is raised.

// File: rtl/stream_xlate_cache.sv
module stream_xlate_cache #(
  parameter int NSTREAM  = 16,
  parameter int ENTRIES  = 8,
  parameter int VA_W     = 32,
  parameter int PA_W     = 36,
  parameter int PG_SHIFT = 14,
  localparam int SID_W   = $clog2(NSTREAM),
  localparam int VPN_W   = VA_W - PG_SHIFT,
  localparam int PPN_W   = PA_W - PG_SHIFT,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [SID_W-1:0] req_stream,
  input  logic [VA_W-1:0]  req_iova,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             walk_req,
  output logic             walk_fresh,
  output logic [SID_W-1:0] walk_stream,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             walk_done,
  input  logic             walk_ok,
  input  logic [PPN_W-1:0] walk_ppn
);
  localparam logic [1:0] A_SEL = 2'd0;
  localparam logic [1:0] A_CMD = 2'd1;
  localparam logic [1:0] A_EN  = 2'd2;
  localparam int INV_BIT  = 20;
  localparam int BUSY_BIT = 2;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT1, S_WAIT2} st_t;
  st_t state;

  logic [NSTREAM-1:0] sel_q, en_q, inv_mask;
  logic               busy;
  logic [IDX_W-1:0]   inv_idx, rr;
  logic [SID_W-1:0]   p_sid;
  logic [VPN_W-1:0]   p_vpn;

  logic [ENTRIES-1:0] e_vld;
  logic [SID_W-1:0]   e_sid [ENTRIES];
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PPN_W-1:0]   e_ppn [ENTRIES];

  logic [ENTRIES-1:0] hit_vec;
  logic [PPN_W-1:0]   hit_ppn;
  logic [VPN_W-1:0]   req_vpn;
  logic               accept, hit, cmd_go, fill;
  logic               unused_bits;

  assign req_vpn   = req_iova[VA_W-1:PG_SHIFT];
  assign req_ready = (state == S_IDLE) && !busy;
  assign accept    = req_valid && req_ready;
  assign hit       = |hit_vec;
  assign cmd_go    = reg_wr && reg_addr == A_CMD && reg_wdata[INV_BIT] && !busy;
  assign fill      = walk_done && walk_ok && state != S_IDLE && !busy;
  assign walk_stream = p_sid;
  assign walk_vpn    = p_vpn;
  assign unused_bits = ^{reg_wdata, req_iova};

  for (genvar i = 0; i < ENTRIES; i++) begin : g_tag
    assign hit_vec[i] = e_vld[i] && e_sid[i] == req_stream && e_vpn[i] == req_vpn;
  end

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hit_vec[i]) hit_ppn = hit_ppn | e_ppn[i];
  end

  always_comb begin
    case (reg_addr)
      A_SEL:   reg_rdata = 32'(sel_q);
      A_CMD:   reg_rdata = 32'(busy) << BUSY_BIT;
      A_EN:    reg_rdata = 32'(en_q);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      en_q     <= '0;
      inv_mask <= '0;
      busy     <= 1'b0;
      inv_idx  <= '0;
    end else begin
      if (reg_wr && reg_addr == A_SEL) sel_q <= reg_wdata[NSTREAM-1:0];
      if (reg_wr && reg_addr == A_EN)  en_q  <= reg_wdata[NSTREAM-1:0];
      if (cmd_go) begin
        busy     <= 1'b1;
        inv_idx  <= '0;
        inv_mask <= sel_q;
      end else if (busy) begin
        inv_idx <= inv_idx + 1'b1;
        if (inv_idx == LAST) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld <= '0;
      rr    <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (busy && inv_idx == IDX_W'(i) && inv_mask[e_sid[i]]) e_vld[i] <= 1'b0;
        else if (fill && rr == IDX_W'(i))                       e_vld[i] <= 1'b1;
      end
      if (fill) rr <= (rr == LAST) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++)
      if (fill && rr == IDX_W'(i)) begin
        e_sid[i] <= p_sid;
        e_vpn[i] <= p_vpn;
        e_ppn[i] <= walk_ppn;
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      rsp_valid  <= 1'b0;
      rsp_fault  <= 1'b0;
      rsp_ppn    <= '0;
      walk_req   <= 1'b0;
      walk_fresh <= 1'b0;
      p_sid      <= '0;
      p_vpn      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      walk_req  <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          p_sid <= req_stream;
          p_vpn <= req_vpn;
          if (!en_q[req_stream]) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b1;
            rsp_ppn   <= '0;
          end else if (hit) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_ppn   <= hit_ppn;
          end else begin
            walk_req   <= 1'b1;
            walk_fresh <= 1'b0;
            state      <= S_WAIT1;
          end
        end
        S_WAIT1: if (walk_done) begin
          if (walk_ok) begin
            rsp_valid <= 1'b1;
            rsp_fault <= 1'b0;
            rsp_ppn   <= walk_ppn;
            state     <= S_IDLE;
          end else begin
            walk_req   <= 1'b1;
            walk_fresh <= 1'b1;
            state      <= S_WAIT2;
          end
        end
        S_WAIT2: if (walk_done) begin
          rsp_valid <= 1'b1;
          rsp_fault <= !walk_ok;
          rsp_ppn   <= walk_ok ? walk_ppn : '0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8
  no_accept_during_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> !req_ready);
  // R2
  walk_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_fresh) |-> $past(req_valid && req_ready));
  // R3
  refetch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && walk_fresh) |-> $past(walk_done && !walk_ok));
  // R4
  disabled_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !en_q[req_stream]) |=> (rsp_valid && rsp_fault && !walk_req));
  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == A_CMD && reg_wdata[INV_BIT]));
  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(inv_idx) == LAST);
  // R5
  unique_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: tb/stream_xlate_cache_tb.sv
module stream_xlate_cache_tb;
  localparam int E = 4;
  localparam int PPN_W = 22;
  localparam int VPN_W = 18;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic req_valid = 0, req_ready;
  logic [3:0] req_stream = 0;
  logic [31:0] req_iova = 0;
  logic rsp_valid, rsp_fault, walk_req, walk_fresh;
  logic [PPN_W-1:0] rsp_ppn, walk_ppn = 0;
  logic [3:0] walk_stream;
  logic [VPN_W-1:0] walk_vpn;
  logic walk_done = 0, walk_ok = 0;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  stream_xlate_cache #(.ENTRIES(E)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_stream(req_stream), .req_iova(req_iova),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_ppn(rsp_ppn),
    .walk_req(walk_req), .walk_fresh(walk_fresh), .walk_stream(walk_stream),
    .walk_vpn(walk_vpn), .walk_done(walk_done), .walk_ok(walk_ok), .walk_ppn(walk_ppn));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic send_req(input logic [3:0] s, input logic [31:0] va);
    req_valid = 1; req_stream = s; req_iova = va;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic walk_reply(input bit ok, input logic [PPN_W-1:0] p);
    walk_done = 1; walk_ok = ok; walk_ppn = p;
    @(negedge clk);
    walk_done = 0; walk_ok = 0;
  endtask

  task automatic wait_busy(output int n);
    reg_addr = 2'd1; #1;
    n = 0;
    while (reg_rdata[2] && n < 100) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic inv_mask(input logic [15:0] m);
    int n;
    reg_write(2'd0, 32'(m));
    reg_write(2'd1, 32'h0010_0000);
    wait_busy(n);
    chk(n == E, "R6 busy length", n, E);
  endtask

  task automatic expect_hit(input logic [3:0] s, input logic [31:0] va,
                            input logic [PPN_W-1:0] p, input string tag);
    send_req(s, va);
    chk(rsp_valid && !rsp_fault && !walk_req && rsp_ppn == p, tag,
        {rsp_valid, rsp_fault, walk_req, 8'h0, rsp_ppn}, {3'b100, 8'h0, p});
  endtask

  task automatic expect_fill(input logic [3:0] s, input logic [31:0] va,
                             input logic [PPN_W-1:0] p, input string tag);
    send_req(s, va);
    chk(walk_req && !walk_fresh && !rsp_valid && walk_stream == s && walk_vpn == va[31:14],
        {tag, " walk"}, {walk_req, walk_fresh, rsp_valid, walk_stream, 4'h0, walk_vpn},
        {3'b100, s, 4'h0, va[31:14]});
    chk(!req_ready, "R8 ready low during walk", req_ready, 0);
    walk_reply(1, p);
    chk(rsp_valid && !rsp_fault && rsp_ppn == p, {tag, " fill rsp"},
        {rsp_valid, rsp_fault, 8'h0, rsp_ppn}, {2'b10, 8'h0, p});
  endtask

  task automatic t_reset;
    reg_addr = 0; #1;
    chk(reg_rdata == 0, "R11 select reg", reg_rdata, 0);
    reg_addr = 1; #1;
    chk(reg_rdata == 0, "R11 command reg", reg_rdata, 0);
    reg_addr = 2; #1;
    chk(reg_rdata == 0, "R11 enable reg", reg_rdata, 0);
    chk(req_ready && !rsp_valid && !walk_req, "R11 outputs",
        {req_ready, rsp_valid, walk_req}, 3'b100);
  endtask

  task automatic t_round_robin;
    for (int k = 1; k <= 5; k++) expect_fill(1, k << 14, 22'(100 + k), "R10 fill");
    for (int k = 2; k <= 5; k++) expect_hit(1, k << 14, 22'(100 + k), "R10 kept");
    expect_fill(1, 1 << 14, 22'd101, "R10 oldest evicted");
    expect_fill(1, 2 << 14, 22'd102, "R10 next oldest evicted");
  endtask

  task automatic t_hit_tags;
    inv_mask(16'hffff);
    expect_fill(2, 32'h0012_3456, 22'h3a5, "R2 miss");
    expect_hit(2, 32'h0012_3456, 22'h3a5, "R1 hit");
    expect_hit(2, 32'h0012_0001, 22'h3a5, "R5 offset ignored");
    expect_fill(7, 32'h0012_3456, 22'h1c4, "R5 other stream misses");
    expect_hit(7, 32'h0012_3fff, 22'h1c4, "R5 stream 7 hit");
    expect_hit(2, 32'h0012_0000, 22'h3a5, "R5 stream 2 still hit");
  endtask

  task automatic t_fault_retry;
    inv_mask(16'hffff);
    send_req(3, 32'h0400_0000);
    chk(walk_req && !walk_fresh, "R2 first walk", {walk_req, walk_fresh}, 2'b10);
    walk_reply(0, 0);
    chk(walk_req && walk_fresh && !rsp_valid, "R3 refetch", {walk_req, walk_fresh, rsp_valid}, 3'b110);
    walk_reply(0, 0);
    chk(rsp_valid && rsp_fault, "R3 double fail faults", {rsp_valid, rsp_fault}, 2'b11);
    send_req(3, 32'h0400_0000);
    chk(walk_req && !walk_fresh, "R3 fault not cached", {walk_req, walk_fresh}, 2'b10);
    walk_reply(0, 0);
    chk(walk_req && walk_fresh, "R3 refetch again", {walk_req, walk_fresh}, 2'b11);
    walk_reply(1, 22'h2bb);
    chk(rsp_valid && !rsp_fault && rsp_ppn == 22'h2bb, "R3 refetch success",
        {rsp_valid, rsp_fault, 8'h0, rsp_ppn}, {2'b10, 8'h0, 22'h2bb});
    expect_hit(3, 32'h0400_0000, 22'h2bb, "R3 refetched cached");
  endtask

  task automatic t_disabled;
    reg_write(2, 32'h0000_ffdf);
    reg_addr = 2; #1;
    chk(reg_rdata == 32'h0000_ffdf, "R4 enable readback", reg_rdata, 32'hffdf);
    send_req(5, 32'h0001_0000);
    chk(rsp_valid && rsp_fault && !walk_req, "R4 disabled stream",
        {rsp_valid, rsp_fault, walk_req}, 3'b110);
    reg_write(2, 32'h0000_ffff);
  endtask

  task automatic t_busy;
    int n;
    reg_write(0, 32'h0);
    reg_write(1, 32'h0010_0000);
    reg_addr = 1; #1;
    chk(reg_rdata[2] == 1, "R6 busy set", reg_rdata[2], 1);
    chk(!req_ready, "R8 ready low while busy", req_ready, 0);
    wait_busy(n);
    chk(n == E, "R6 busy cycles", n, E);
    chk(req_ready, "R8 ready after busy", req_ready, 1);
  endtask

  task automatic t_selective;
    inv_mask(16'hffff);
    expect_fill(3, 32'h0008_0000, 22'h11, "R7 fill s3");
    expect_fill(4, 32'h0008_0000, 22'h22, "R7 fill s4");
    expect_fill(6, 32'h000c_0000, 22'h33, "R7 fill s6");
    inv_mask(16'h0048);
    expect_hit(4, 32'h0008_0000, 22'h22, "R7 unselected kept");
    expect_fill(3, 32'h0008_0000, 22'h11, "R7 s3 removed");
    expect_fill(6, 32'h000c_0000, 22'h33, "R7 s6 removed");
  endtask

  task automatic t_fill_busy;
    int n;
    inv_mask(16'hffff);
    send_req(9, 32'h0030_0000);
    chk(walk_req, "R9 walk started", walk_req, 1);
    reg_write(0, 32'h0);
    reg_write(1, 32'h0010_0000);
    walk_reply(1, 22'h99);
    chk(rsp_valid && !rsp_fault && rsp_ppn == 22'h99, "R9 result delivered",
        {rsp_valid, rsp_fault, 8'h0, rsp_ppn}, {2'b10, 8'h0, 22'h99});
    wait_busy(n);
    expect_fill(9, 32'h0030_0000, 22'h99, "R9 not cached");
  endtask

  task automatic t_plain_cmd;
    reg_write(1, 32'h0000_0004);
    reg_addr = 1; #1;
    chk(reg_rdata[2] == 0 && req_ready, "R12 no busy", {reg_rdata[2], req_ready}, 2'b01);
    expect_hit(9, 32'h0030_0000, 22'h99, "R12 entry intact");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    reg_write(2, 32'h0000_ffff);
    t_round_robin();
    t_hit_tags();
    t_fault_retry();
    t_disabled();
    t_busy();
    t_selective();
    t_fill_busy();
    t_plain_cmd();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule